// File: doc/BRIEF.md
# Dual Programmable Limit Timer

This block provides two identical up-counting timers that share one auxiliary register bus. Each timer owns three registers: a count, a limit and a control word. The count advances by one on every clock edge. When an advancing edge finds the count equal to the limit, the count returns to zero on that edge. If interrupts are enabled for that timer, a pending flag is set at the same moment. The flag drives a level interrupt output until software acknowledges it. Software acknowledges by writing anything at all to that timer's control register.

A control bit can make a timer freeze while the processor reports that it is halted. This keeps debug stops from consuming timer intervals. One instance usually serves as the periodic or one-shot event tick. For that use, software writes the limit, then a zero count, then the control bits. The other instance is left with the limit at all ones, so it runs as a free counter that wraps through zero. Reads are combinational from the addressed register. Addresses that match no register read as zero.

Top module: `aux_limit_timer`

## Requirements
- R1: Reset leaves both timers with count 0, limit 0xFFFFFFFF, control 0 and both interrupt outputs low.
- R2: The count increases by exactly one per clock. A write to a count register loads the written value on that edge, replacing the increment.
- R3: On an advancing edge where the count equals the limit, the next count is 0. This includes a limit of 0xFFFFFFFF, where the counter wraps through zero.
- R4: Control bit 0 enables interrupts. A wrap while bit 0 is 1 sets a pending flag. The interrupt output is high while the flag is set and bit 0 is 1, and it stays high until acknowledged.
- R5: Any write to a control register clears that timer's pending flag, whatever data is written. If a wrap with bit 0 set occurs on the same edge, the flag is set instead.
- R6: Control bit 1 enables halt gating. While it is 1 and the halt input is high, the count holds. A count write still loads.
- R7: Timer 0 decodes count, control and limit at addresses 0x021, 0x022 and 0x023. Timer 1 decodes them at 0x100, 0x101 and 0x102. Control reads return bits 1:0 as stored, with all other bits 0.
- R8: Reads of undecoded addresses return 0. Writes to undecoded addresses change no register.
- R9: The two timers are independent. Register writes, wraps and interrupts of one timer do not alter the other timer's registers or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_halt_i | input | 1 | High while the processor is halted |
| aux_addr_i | input | 12 | Register address for reads and writes |
| aux_wr_i | input | 1 | Write strobe, one cycle per write |
| aux_wdata_i | input | 32 | Write data |
| aux_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| tmr_irq_o | output | 2 | Level interrupt per timer, bit 0 for timer 0 |

## Verification
A corrupted count or limit register appears on the read port in the same cycle that it is addressed. Because the count moves every cycle, an off-by-one in the increment or in the wrap point shows up within one interval, as a wrong value read back or a wrap on the wrong edge. A pending flag that is set wrongly, or that fails to clear, reaches the interrupt output on the edge after the wrap or the acknowledge write. The acknowledge-versus-wrap collision is driven on the exact edge where both occur, so a wrong priority shows as an interrupt level of the wrong value one cycle later.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
   // register slot offsets from a timer's base address
   localparam int FLD_CNT  = 0;
   localparam int FLD_CTRL = 1;
   localparam int FLD_LIM  = 2;
   localparam int NUM_FLD  = 3;

   // control word bit positions
   localparam int CTL_IE = 0;
   localparam int CTL_NH = 1;
   localparam int CTL_W  = 2;

   typedef struct packed {
      logic nh;   // bit 1: hold while processor halted
      logic ie;   // bit 0: interrupt enable
   } ctl_t;
endpackage

// File: rtl/ltmr_decode.sv
module ltmr_decode
   import ltmr_pkg::*;
#(
   parameter int NUM_TMR = 2,
   parameter int ADDR_W  = 12,
   parameter logic [NUM_TMR*ADDR_W-1:0] BASES = {12'h100, 12'h021}
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 addr_i,
   output logic [NUM_TMR-1:0][NUM_FLD-1:0]   hit_o
);
   localparam int HIT_W = NUM_TMR * NUM_FLD;

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      localparam logic [ADDR_W-1:0] BASE = BASES[t*ADDR_W +: ADDR_W];
      for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
         localparam logic [ADDR_W-1:0] SLOT = BASE + ADDR_W'(f);
         assign hit_o[t][f] = (addr_i == SLOT);
      end
   end

   logic [HIT_W-1:0] hit_flat;
   assign hit_flat = hit_o;

   // overlapping base parameters would make one address select two registers
   assert_single_select_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_flat));
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
   import ltmr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                halt_i,
   input  logic [NUM_FLD-1:0]  sel_i,
   input  logic                wr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                irq_o
);
   localparam logic [DATA_W-1:0] LIM_RST = '1;
   localparam int PAD_W = DATA_W - CTL_W;

   logic [DATA_W-1:0] cnt_q, lim_q;
   ctl_t              ctl_q;
   logic              pend_q;

   logic cnt_wr, lim_wr, ctl_wr, run, hit;

   assign cnt_wr = wr_i & sel_i[FLD_CNT];
   assign lim_wr = wr_i & sel_i[FLD_LIM];
   assign ctl_wr = wr_i & sel_i[FLD_CTRL];
   assign run    = !(ctl_q.nh && halt_i);
   assign hit    = run && (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lim_q  <= LIM_RST;
         ctl_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (cnt_wr)
            cnt_q <= wdata_i;
         else if (run)
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
         if (lim_wr)
            lim_q <= wdata_i;
         if (ctl_wr)
            ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
         if (hit && ctl_q.ie)
            pend_q <= 1'b1;
         else if (ctl_wr)
            pend_q <= 1'b0;
      end
   end

   assign irq_o = pend_q & ctl_q.ie;

   always_comb begin
      rdata_o = '0;
      if (sel_i[FLD_CNT])  rdata_o = cnt_q;
      if (sel_i[FLD_LIM])  rdata_o = lim_q;
      if (sel_i[FLD_CTRL]) rdata_o = {{PAD_W{1'b0}}, ctl_q};
   end

   assert_count_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_q == $past(wdata_i));
   assert_count_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && run && !hit) |=> cnt_q == $past(cnt_q) + 1'b1);
   assert_wrap_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && hit) |=> cnt_q == '0);
   assert_pend_set_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctl_q.ie) |=> pend_q);
   assert_ack_clear_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !(hit && ctl_q.ie)) |=> !pend_q);
   assert_halt_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.nh && halt_i && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/aux_limit_timer.sv
module aux_limit_timer
   import ltmr_pkg::*;
#(
   parameter int NUM_TMR = 2,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter logic [NUM_TMR*ADDR_W-1:0] BASES = {12'h100, 12'h021}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_halt_i,
   input  logic [ADDR_W-1:0]   aux_addr_i,
   input  logic                aux_wr_i,
   input  logic [DATA_W-1:0]   aux_wdata_i,
   output logic [DATA_W-1:0]   aux_rdata_o,
   output logic [NUM_TMR-1:0]  tmr_irq_o
);
   if (DATA_W < CTL_W + 1 || DATA_W > 64) begin : g_bad_width
      $error("aux_limit_timer: DATA_W out of range");
   end
   if (NUM_TMR < 1 || NUM_TMR > 8) begin : g_bad_count
      $error("aux_limit_timer: NUM_TMR out of range");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("aux_limit_timer: ADDR_W too small");
   end

   logic [NUM_TMR-1:0][NUM_FLD-1:0] hit;
   logic [NUM_TMR-1:0][DATA_W-1:0]  rd_each;

   ltmr_decode #(
      .NUM_TMR (NUM_TMR),
      .ADDR_W  (ADDR_W),
      .BASES   (BASES)
   ) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (aux_addr_i),
      .hit_o  (hit)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      ltmr_core #(
         .DATA_W (DATA_W)
      ) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .halt_i  (cpu_halt_i),
         .sel_i   (hit[t]),
         .wr_i    (aux_wr_i),
         .wdata_i (aux_wdata_i),
         .rdata_o (rd_each[t]),
         .irq_o   (tmr_irq_o[t])
      );
   end

   // at most one core is selected, so an OR merges the read paths
   always_comb begin
      aux_rdata_o = '0;
      for (int t = 0; t < NUM_TMR; t++)
         aux_rdata_o = aux_rdata_o | rd_each[t];
   end

   assert_undecoded_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (aux_rdata_o == '0));
endmodule

// File: tb/aux_limit_timer_tb.sv
module aux_limit_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_halt_i = 1'b0;
   logic [11:0] aux_addr_i = '0;
   logic        aux_wr_i = 1'b0;
   logic [31:0] aux_wdata_i = '0;
   logic [31:0] aux_rdata_o;
   logic [1:0]  tmr_irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   aux_limit_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_halt_i  (cpu_halt_i),
      .aux_addr_i  (aux_addr_i),
      .aux_wr_i    (aux_wr_i),
      .aux_wdata_i (aux_wdata_i),
      .aux_rdata_o (aux_rdata_o),
      .tmr_irq_o   (tmr_irq_o)
   );

   // entry: {is_write, address, data or expected read}
   localparam int NV = 19;
   localparam logic [44:0] VEC [NV] = '{
      {1'b1, 12'h023, 32'd5},           // T0 limit 5
      {1'b1, 12'h021, 32'd0},           // T0 count 0
      {1'b0, 12'h021, 32'd0},           // R2
      {1'b0, 12'h021, 32'd1},           // R2
      {1'b0, 12'h023, 32'd5},           // R7 limit readback
      {1'b0, 12'h022, 32'd0},           // R7 control readback
      {1'b0, 12'h024, 32'd0},           // R8 undecoded
      {1'b0, 12'h021, 32'd5},           // R3 at limit
      {1'b0, 12'h021, 32'd0},           // R3 wrapped
      {1'b0, 12'h021, 32'd1},           // R3
      {1'b1, 12'h102, 32'hFFFF_FFFF},   // T1 limit all ones
      {1'b1, 12'h100, 32'hFFFF_FFFE},   // T1 count near top
      {1'b0, 12'h100, 32'hFFFF_FFFE},   // R2 load
      {1'b0, 12'h100, 32'hFFFF_FFFF},   // R3 top
      {1'b0, 12'h100, 32'h0000_0000},   // R3 free-run wrap
      {1'b0, 12'h100, 32'h0000_0001},   // R3
      {1'b1, 12'h101, 32'hFFFF_FFFF},   // T1 control all ones
      {1'b0, 12'h101, 32'h0000_0003},   // R7 only bits 1:0 kept
      {1'b1, 12'h101, 32'h0000_0000}    // T1 control off
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      aux_addr_i = a; aux_wdata_i = d; aux_wr_i = 1'b1;
      @(negedge clk);
      aux_wr_i = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      aux_addr_i = a; aux_wr_i = 1'b0;
      #1;
      check(req, aux_rdata_o, exp);
   endtask

   task automatic irq_chk(input string req, input logic [1:0] exp);
      #1;
      check(req, {30'd0, tmr_irq_o}, {30'd0, exp});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values, sampled while reset is still held
      rd_chk("R1 t0 count", 12'h021, 32'd0);
      rd_chk("R1 t0 limit", 12'h023, 32'hFFFF_FFFF);
      rd_chk("R1 t0 ctrl",  12'h022, 32'd0);
      rd_chk("R1 t1 limit", 12'h102, 32'hFFFF_FFFF);
      irq_chk("R1 irq", 2'b00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][44]) begin
            wr(VEC[v][43:32], VEC[v][31:0]);
         end else begin
            rd_chk($sformatf("R2/R3/R7/R8 vector %0d", v), VEC[v][43:32], VEC[v][31:0]);
            @(negedge clk);
         end
      end

      // R4 interrupt on wrap, level until acknowledged
      wr(12'h023, 32'd3);
      wr(12'h021, 32'd0);
      wr(12'h022, 32'd1);
      tick(2);
      rd_chk("R4 pre-wrap count", 12'h021, 32'd3);
      irq_chk("R4 no irq before wrap", 2'b00);
      tick(1);
      irq_chk("R4 irq after wrap", 2'b01);
      rd_chk("R3 wrapped to zero", 12'h021, 32'd0);
      tick(2);
      irq_chk("R4 irq stays level", 2'b01);
      // R5 acknowledge by writing the control register
      wr(12'h022, 32'd1);
      irq_chk("R5 ack clears", 2'b00);
      tick(1);
      irq_chk("R4 rearmed wrap", 2'b01);
      wr(12'h022, 32'd0);
      irq_chk("R5 ack with zero", 2'b00);
      tick(4);
      irq_chk("R4 no irq with enable off", 2'b00);
      rd_chk("R3 count after two wraps", 12'h021, 32'd1);

      // R5 wrap and acknowledge on the same edge: wrap wins
      wr(12'h021, 32'd0);
      wr(12'h022, 32'd1);
      tick(2);
      rd_chk("R5 at limit", 12'h021, 32'd3);
      wr(12'h022, 32'd1);
      irq_chk("R5 wrap beats ack, R9 t1 quiet", 2'b01);
      wr(12'h022, 32'd0);
      irq_chk("R5 cleared", 2'b00);

      // R6 halt gating
      wr(12'h023, 32'd100);
      wr(12'h021, 32'd10);
      wr(12'h022, 32'd2);
      cpu_halt_i = 1'b1;
      tick(3);
      rd_chk("R6 held while halted", 12'h021, 32'd11);
      wr(12'h021, 32'd20);
      tick(1);
      rd_chk("R6 load while halted", 12'h021, 32'd20);
      wr(12'h022, 32'd0);
      rd_chk("R6 held on gating-off edge", 12'h021, 32'd20);
      tick(1);
      rd_chk("R6 runs with gating off", 12'h021, 32'd21);
      cpu_halt_i = 1'b0;

      // R8 write to an undecoded address
      wr(12'h103, 32'd5);
      rd_chk("R8 t1 limit untouched", 12'h102, 32'hFFFF_FFFF);
      rd_chk("R8 undecoded read", 12'h103, 32'd0);

      // R9 timer 1 interrupt independent of timer 0
      wr(12'h102, 32'd2);
      wr(12'h100, 32'd0);
      wr(12'h101, 32'd1);
      tick(2);
      irq_chk("R9 t1 irq only", 2'b10);
      rd_chk("R9 t0 limit kept", 12'h023, 32'd100);
      wr(12'h022, 32'd0);
      irq_chk("R9 t0 ack leaves t1", 2'b10);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule